// File: doc/BRIEF.md
# Watchdog Power-Up Self-Test Sequencer

This block carries out the opening phase of the power-on check of an external hardware watchdog. A start strobe tells it that the input/output modules are ready. It then begins kicking the watchdog at a fixed, valid spacing and raises a trigger request toward a second supervisor. It waits for that supervisor to answer with a release acknowledge. The release is accepted only if the switched output voltage is reported low at that moment. After a valid release, the block waits for the switched supply to report that it is up, within a bounded time. It then finishes in a pass or fail state.

All timing is counted in cycles of a tick enable input. The kick spacing, the request timeout and the supply timeout are parameters. Kicking runs only while the test is busy. Once the block reaches a verdict it stops kicking, and the regular kick source has to take over. A later start strobe repeats the test.

Top module: `wdt_selftest_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, kick, request, busy, pass and fail are all low.
- R2: A start strobe sampled while idle, passed or failed makes busy and request high from the next cycle. A start strobe sampled while busy has no effect.
- R3: kick is a one-cycle pulse. The first pulse is high in the cycle right after the accepted start strobe. Each later pulse follows after exactly KICK_PERIOD sampled tick enables. kick is never high while busy is low.
- R4: request stays high from the cycle after start until a release acknowledge is sampled while waiting for release. It is low in every other state.
- R5: A release acknowledge sampled together with voltage-low high moves the block to the supply wait. From the next cycle request is low and busy stays high.
- R6: A release acknowledge sampled together with voltage-low low makes fail high from the next cycle.
- R7: Suppose no release acknowledge arrives and REQ_TIMEOUT tick enables are sampled while waiting for release. Then fail is high from the cycle after the last of those ticks. An acknowledge sampled in the same cycle as that last tick takes priority.
- R8: A supply-OK sampled during the supply wait makes pass high from the next cycle. If SUPPLY_TIMEOUT tick enables are sampled first, fail goes high instead. Supply-OK in the same cycle as the last tick takes priority.
- R9: pass and fail are never high together. Each holds, with busy low and no kicks, until reset or an accepted start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Time base enable; all periods and timeouts count these |
| startStb | input | 1 | Modules initialised, begin the test |
| relAck | input | 1 | Release acknowledge from the second supervisor |
| voltLow | input | 1 | Switched output voltage is below its safe limit |
| supplyOk | input | 1 | Switched supply has reached its level |
| kick | output | 1 | Watchdog trigger pulse |
| request | output | 1 | Trigger request toward the second supervisor |
| busy | output | 1 | Test in progress |
| pass | output | 1 | Phase completed successfully |
| fail | output | 1 | Phase failed |

## Verification
A wrong internal state shows at the ports in the next cycle, because request, busy, pass and fail decode the state register directly. A stuck or misloaded kick counter shows up as a pulse at the wrong place, or one missing, within KICK_PERIOD tick enables. A timer fault moves the fail verdict by one or more ticks around the exact timeout boundary. The bench therefore drives acknowledge and supply-OK onto the final tick, and also one tick early.

// File: rtl/wst_pkg.sv
package wst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_KICK_REQ    = 3'd1,
    ST_WAIT_REL    = 3'd2,
    ST_WAIT_SUPPLY = 3'd3,
    ST_PASS        = 3'd4,
    ST_FAIL        = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic kickStart;  // restart kick spacing, pulse now
    logic kickRun;    // test stays busy next cycle
    logic tmrClr;     // state changes: restart timeout count
  } dpCtl_t;

  function automatic logic isBusyState(seqState_t s);
    return (s == ST_KICK_REQ) || (s == ST_WAIT_REL) || (s == ST_WAIT_SUPPLY);
  endfunction

endpackage

// File: rtl/wst_datapath.sv
module wst_datapath
  import wst_pkg::*;
#(
  parameter int KICK_PERIOD    = 500,
  parameter int REQ_TIMEOUT    = 2000,
  parameter int SUPPLY_TIMEOUT = 1000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tickEn,
  input  dpCtl_t ctl,
  output logic   kick,
  output logic   reqExpire,
  output logic   supExpire
);

  localparam int MaxTmo = (REQ_TIMEOUT > SUPPLY_TIMEOUT) ? REQ_TIMEOUT : SUPPLY_TIMEOUT;
  localparam int TmrW   = $clog2(MaxTmo + 1);
  localparam int KickW  = $clog2(KICK_PERIOD + 1);
  localparam logic [KickW-1:0] KickLast = KickW'(KICK_PERIOD - 1);
  localparam logic [TmrW-1:0]  ReqLast  = TmrW'(REQ_TIMEOUT - 1);
  localparam logic [TmrW-1:0]  SupLast  = TmrW'(SUPPLY_TIMEOUT - 1);

  logic [KickW-1:0] kickCnt;
  logic [TmrW-1:0]  tmr;
  logic             kickQ;

  // kick spacing generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kickQ   <= 1'b0;
      kickCnt <= '0;
    end else if (ctl.kickStart) begin
      kickQ   <= 1'b1;
      kickCnt <= '0;
    end else if (ctl.kickRun) begin
      if (tickEn) begin
        if (kickCnt == KickLast) begin
          kickQ   <= 1'b1;
          kickCnt <= '0;
        end else begin
          kickQ   <= 1'b0;
          kickCnt <= kickCnt + 1'b1;
        end
      end else begin
        kickQ <= 1'b0;
      end
    end else begin
      kickQ   <= 1'b0;
      kickCnt <= '0;
    end
  end

  // timeout counter, restarted on every state change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (ctl.tmrClr) begin
      tmr <= '0;
    end else if (tickEn && ctl.kickRun && (tmr != {TmrW{1'b1}})) begin
      tmr <= tmr + 1'b1;
    end
  end

  assign kick      = kickQ;
  assign reqExpire = tickEn && (tmr == ReqLast);
  assign supExpire = tickEn && (tmr == SupLast);

  // R3
  kick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    kickQ |=> !kickQ)
    else $error("kick wider than one cycle");

  // R3
  kick_only_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.kickRun && !ctl.kickStart) |=> !kickQ)
    else $error("kick while not running");

endmodule

// File: rtl/wst_ctrl.sv
module wst_ctrl
  import wst_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startStb,
  input  logic   relAck,
  input  logic   voltLow,
  input  logic   supplyOk,
  input  logic   reqExpire,
  input  logic   supExpire,
  output dpCtl_t ctl,
  output logic   request,
  output logic   busy,
  output logic   pass,
  output logic   fail
);

  seqState_t state, nextState;
  logic      canStart;

  assign canStart = (state == ST_IDLE) || (state == ST_PASS) || (state == ST_FAIL);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:        if (startStb) nextState = ST_KICK_REQ;
      ST_KICK_REQ:    nextState = ST_WAIT_REL;
      ST_WAIT_REL: begin
        if (relAck)         nextState = voltLow ? ST_WAIT_SUPPLY : ST_FAIL;
        else if (reqExpire) nextState = ST_FAIL;
      end
      ST_WAIT_SUPPLY: begin
        if (supplyOk)       nextState = ST_PASS;
        else if (supExpire) nextState = ST_FAIL;
      end
      ST_PASS:        if (startStb) nextState = ST_KICK_REQ;
      ST_FAIL:        if (startStb) nextState = ST_KICK_REQ;
      default:        nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl.kickStart = startStb && canStart;
    ctl.kickRun   = isBusyState(nextState);
    ctl.tmrClr    = (nextState != state);
  end

  assign request = (state == ST_KICK_REQ) || (state == ST_WAIT_REL);
  assign busy    = isBusyState(state);
  assign pass    = (state == ST_PASS);
  assign fail    = (state == ST_FAIL);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (request && !relAck && !reqExpire) |=> request)
    else $error("request dropped early");

  // R6
  rel_bad_volt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_REL && relAck && !voltLow) |=> fail)
    else $error("release without low voltage not failed");

  // R5
  rel_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_REL && relAck && voltLow) |=> (busy && !request))
    else $error("good release not accepted");

  // R8
  supply_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_SUPPLY && supplyOk) |=> pass)
    else $error("supply ok not passed");

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pass || fail) && !startStb) |=> $stable({pass, fail}))
    else $error("verdict not held");

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_SUPPLY && startStb && !supplyOk && !supExpire) |=> (state == ST_WAIT_SUPPLY))
    else $error("start disturbed running test");

endmodule

// File: rtl/wdt_selftest_seq.sv
module wdt_selftest_seq
  import wst_pkg::*;
#(
  parameter int KICK_PERIOD    = 500,
  parameter int REQ_TIMEOUT    = 2000,
  parameter int SUPPLY_TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic startStb,
  input  logic relAck,
  input  logic voltLow,
  input  logic supplyOk,
  output logic kick,
  output logic request,
  output logic busy,
  output logic pass,
  output logic fail
);

  dpCtl_t ctl;
  logic   reqExpire;
  logic   supExpire;

  wst_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .relAck    (relAck),
    .voltLow   (voltLow),
    .supplyOk  (supplyOk),
    .reqExpire (reqExpire),
    .supExpire (supExpire),
    .ctl       (ctl),
    .request   (request),
    .busy      (busy),
    .pass      (pass),
    .fail      (fail)
  );

  wst_datapath #(
    .KICK_PERIOD    (KICK_PERIOD),
    .REQ_TIMEOUT    (REQ_TIMEOUT),
    .SUPPLY_TIMEOUT (SUPPLY_TIMEOUT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .ctl       (ctl),
    .kick      (kick),
    .reqExpire (reqExpire),
    .supExpire (supExpire)
  );

  // R3
  kick_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    kick |-> busy)
    else $error("kick outside test");

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail) && !((pass || fail) && busy))
    else $error("verdict overlap");

endmodule

// File: tb/wdt_selftest_seq_test.sv
module wdt_selftest_seq_test;

  localparam int P   = 5;
  localparam int REQ = 12;
  localparam int SUP = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, startStb = 1'b0, relAck = 1'b0, voltLow = 1'b0, supplyOk = 1'b0;
  logic kick, request, busy, pass, fail;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state: 0 idle,1 kick+req,2 wait rel,3 wait supply,4 pass,5 fail
  int mState = 0, mTmr = 0, mKcnt = 0;
  bit mKick = 1'b0;

  wdt_selftest_seq #(.KICK_PERIOD(P), .REQ_TIMEOUT(REQ), .SUPPLY_TIMEOUT(SUP)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startStb(startStb), .relAck(relAck),
    .voltLow(voltLow), .supplyOk(supplyOk), .kick(kick), .request(request),
    .busy(busy), .pass(pass), .fail(fail));

  always #2 clk = ~clk;

  function automatic bit busyOf(int s);
    return (s >= 1) && (s <= 3);
  endfunction

  function automatic int nextOf(int s, bit st, bit ack, bit vl, bit so, bit tk, int tmr);
    case (s)
      0: return st ? 1 : 0;
      1: return 2;
      2: if (ack) return vl ? 3 : 5;
         else if (tk && tmr == REQ - 1) return 5;
         else return 2;
      3: if (so) return 4;
         else if (tk && tmr == SUP - 1) return 5;
         else return 3;
      default: return st ? 1 : s;
    endcase
  endfunction

  task automatic check(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R3", "kick",    kick,    mKick);
    check("R4", "request", request, (mState == 1) || (mState == 2));
    check("R2", "busy",    busy,    busyOf(mState));
    check("R8", "pass",    pass,    mState == 4);
    check("R7", "fail",    fail,    mState == 5);
  endtask

  // one cycle: compare at negedge, drive, advance model, wait next negedge
  task automatic step(bit st, bit ack, bit vl, bit so, bit tk);
    int nxt;
    compareAll();
    startStb = st; relAck = ack; voltLow = vl; supplyOk = so; tickEn = tk;
    nxt = nextOf(mState, st, ack, vl, so, tk, mTmr);
    if (st && (mState == 0 || mState >= 4)) begin
      mKick = 1'b1; mKcnt = 0;
    end else if (busyOf(nxt)) begin
      if (tk) begin
        if (mKcnt == P - 1) begin mKick = 1'b1; mKcnt = 0; end
        else begin mKick = 1'b0; mKcnt++; end
      end else mKick = 1'b0;
    end else begin
      mKick = 1'b0; mKcnt = 0;
    end
    if (nxt != mState) mTmr = 0;
    else if (tk && busyOf(nxt)) mTmr++;
    mState = nxt;
    @(negedge clk);
  endtask

  task automatic idleSteps(int n, bit tk);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b0, tk);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired: run hung");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check("R1", "kick in reset", kick, 1'b0);
    check("R1", "busy in reset", busy, 1'b0);
    check("R1", "pass in reset", pass, 1'b0);
    check("R1", "fail in reset", fail, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "request after reset", request, 1'b0);

    // directed: R2/R3/R4/R5/R8 good run, ack and supply on boundary ticks
    step(1'b1, 0, 1, 0, 1);
    check("R2", "busy after start", busy, 1'b1);
    check("R3", "first kick", kick, 1'b1);
    step(0, 0, 1, 0, 1);                      // kick+req cycle
    for (int i = 0; i < REQ - 1; i++) step(1'b1, 0, 1, 0, 1); // R2 start ignored
    step(0, 1, 1, 0, 1);                      // R7 ack on final tick wins
    check("R5", "request low after release", request, 1'b0);
    check("R5", "busy in supply wait", busy, 1'b1);
    for (int i = 0; i < SUP - 1; i++) step(0, 0, 1, 0, 1);
    step(0, 0, 1, 1, 1);                      // R8 supply on final tick wins
    check("R8", "pass", pass, 1'b1);
    idleSteps(2 * P, 1);                      // R9 no kicks while passed
    check("R9", "pass held", pass, 1'b1);

    // R7: request timeout
    step(1, 0, 1, 0, 1);
    step(0, 0, 1, 0, 1);
    for (int i = 0; i < REQ; i++) step(0, 0, 1, 0, 1);
    check("R7", "fail on request timeout", fail, 1'b1);

    // R6: release while voltage not low
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0);
    check("R6", "fail on bad voltage", fail, 1'b1);

    // R8: supply timeout, supply-OK one tick late
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 1, 1, 0, 0);
    for (int i = 0; i < SUP; i++) step(0, 0, 1, 0, 1);
    step(0, 0, 1, 1, 1);
    check("R8", "fail on supply timeout", fail, 1'b1);
    check("R9", "no pass with fail", pass, 1'b0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit st, ack, vl, so, tk;
      st  = ($urandom % 100) < 3;
      ack = ($urandom % 100) < 8;
      vl  = ($urandom % 100) < 80;
      so  = ($urandom % 100) < 10;
      tk  = ($urandom % 100) < 60;
      step(st, ack, vl, so, tk);
    end

    // reset mid-test
    step(1, 0, 1, 0, 1);
    rstN = 1'b0;
    mState = 0; mKick = 0; mKcnt = 0; mTmr = 0;
    @(negedge clk);
    check("R1", "busy cleared by reset", busy, 1'b0);
    rstN = 1'b1;
    idleSteps(3, 1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule